// File: doc/BRIEF.md
# Sampling Delay Window Tuner

This block calibrates the sampling point of a receive path. After a start pulse it steps a delay tap through every setting, first on the rising sampling edge. At each tap it asks an external agent to run a test transfer. The agent returns a pass or fail result for each request. From the results the block builds a pass map with one bit per tap. It then searches the map for the widest run of passing taps and chooses a tap inside that run.

If the rising-edge window is too narrow, the whole sweep is repeated on the falling edge. The better of the two edges is kept. At the end the block leaves the chosen tap and edge on its control outputs. It also reports the chosen tap code, the window length and the window start, and raises a fail flag when no tap passed.

Top module: `delay_window_tuner`

## Requirements
- R1: After start, the tap output steps through settings 0 to 31 with `edgeSel` low. If a falling scan is needed, the sweep repeats with `edgeSel` high. Tap and edge stay constant while a test request waits for its acknowledge.
- R2: Each tap receives up to three test requests. The tap counts as passing only if all three pass, and the first failing result ends the requests for that tap.
- R3: The window search starts at tap 0 and measures the run of consecutive passing taps at each start point. It keeps the first longest run, and a run never wraps past tap 31. The search then moves on by the run length, or by one tap after an empty run. `winStart` and `winLen` report the kept run of the chosen edge.
- R4: The search stops early once it finishes a run of 12 or more taps while the kept run starts below tap 4.
- R5: When the kept run starts at tap 0, the chosen tap is the start plus one third of the length, rounded down. Otherwise it is the start plus half the length, rounded down, modulo 32. `finalTap` carries the chosen tap in its low bits.
- R6: When the chosen edge has no passing tap, `finalTap` reads 0xFF, `fail` is 1, `winLen` and `winStart` read 0, and `tapSel` returns 0.
- R7: The falling scan is skipped when the rising run is at least 12 taps long, or when it starts at tap 0 and is at least 4 taps long. A skipped scan issues no test requests with `edgeSel` high.
- R8: After both scans, the falling edge is chosen only if its run is strictly longer, so a tie goes to the rising edge. Once `done` is asserted, `edgeSel` shows the chosen edge (1 = falling) and `tapSel` shows the chosen tap.
- R9: `done` is high for exactly one cycle. The results stay unchanged from then until the next calibration completes.
- R10: A start pulse that arrives while a calibration is running is ignored and does not restart the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a calibration |
| testReq | output | 1 | Request for one test transfer at the current tap and edge |
| testAck | input | 1 | Result of the requested transfer is valid |
| testPass | input | 1 | Transfer passed, sampled with `testAck` |
| tapSel | output | 5 | Delay tap under test, then the chosen tap |
| edgeSel | output | 1 | Sampling edge: 0 rising, 1 falling |
| finalTap | output | 8 | Chosen tap, or 0xFF on failure |
| winLen | output | 6 | Length of the kept window |
| winStart | output | 5 | First tap of the kept window |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No passing tap on the chosen edge |

## Verification
A request is acknowledged half a cycle after it first shows at a falling clock edge. The block consumes the acknowledge at the next rising edge and always drops `testReq` for one cycle before issuing the next request. The bench model therefore sees each trial exactly once and can count trials per tap and per edge. The results, `edgeSel` and `tapSel` are all updated on the same rising edge that raises `done`. The bench samples them at the falling edge where `done` is first seen high. It checks that `done` has fallen one cycle later, and it checks again after a few idle cycles that the results have not moved.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  localparam int DEF_TAP_W       = 5;
  localparam int DEF_TRIALS      = 3;
  localparam int DEF_EARLY_LEN   = 12;
  localparam int DEF_EARLY_START = 4;
  localparam int DEF_SHORT_LEN   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_SEARCH,
    ST_FINISH
  } tuneState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearScan;
    logic recordBit;
    logic bitVal;
    logic searchStep;
    logic saveRise;
    logic commit;
    logic fallDone;
  } tuneStrobe_t;

endpackage

// File: rtl/tuner_ctrl.sv
module tuner_ctrl
  import tuner_pkg::*;
#(
  parameter int TAP_W  = DEF_TAP_W,
  parameter int TRIALS = DEF_TRIALS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             testAck,
  input  logic             testPass,
  input  logic             searchFin,
  input  logic             skipFall,
  output logic             testReq,
  output logic [TAP_W-1:0] scanTap,
  output logic             scanEdge,
  output logic             busy,
  output logic             done,
  output tuneStrobe_t      strb
);

  localparam int TRIAL_W = $clog2(TRIALS + 1);
  localparam logic [TRIAL_W-1:0] LAST_TRIAL = TRIAL_W'(TRIALS - 1);
  localparam logic [TAP_W-1:0]   LAST_TAP   = '1;

  tuneState_t state;
  logic [TAP_W-1:0]   tap;
  logic [TRIAL_W-1:0] trial;
  logic               fallEdge;
  logic               lastTrial;

  assign lastTrial = !testPass || (trial == LAST_TRIAL);
  assign testReq   = (state == ST_REQ);
  assign scanTap   = tap;
  assign scanEdge  = fallEdge;
  assign busy      = (state == ST_REQ) || (state == ST_GAP) || (state == ST_SEARCH);
  assign done      = (state == ST_FINISH);

  always_comb begin
    strb          = '0;
    strb.bitVal   = testPass;
    strb.fallDone = fallEdge;
    case (state)
      ST_IDLE:   strb.clearScan = start;
      ST_REQ:    strb.recordBit = testAck && lastTrial;
      ST_SEARCH: begin
        if (!searchFin) begin
          strb.searchStep = 1'b1;
        end else if (!fallEdge) begin
          strb.saveRise  = 1'b1;
          strb.commit    = skipFall;
          strb.clearScan = !skipFall;
        end else begin
          strb.commit = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tap      <= '0;
      trial    <= '0;
      fallEdge <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          tap      <= '0;
          trial    <= '0;
          fallEdge <= 1'b0;
          state    <= ST_REQ;
        end
        ST_REQ: if (testAck) begin
          if (lastTrial) begin
            trial <= '0;
            if (tap == LAST_TAP) begin
              state <= ST_SEARCH;
            end else begin
              tap   <= tap + 1'b1;
              state <= ST_GAP;
            end
          end else begin
            trial <= trial + 1'b1;
            state <= ST_GAP;
          end
        end
        ST_GAP: state <= ST_REQ;
        ST_SEARCH: if (searchFin) begin
          if (!fallEdge && !skipFall) begin
            fallEdge <= 1'b1;
            tap      <= '0;
            trial    <= '0;
            state    <= ST_REQ;
          end else begin
            state <= ST_FINISH;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tuner_datapath.sv
module tuner_datapath
  import tuner_pkg::*;
#(
  parameter int TAP_W       = DEF_TAP_W,
  parameter int EARLY_LEN   = DEF_EARLY_LEN,
  parameter int EARLY_START = DEF_EARLY_START,
  parameter int SHORT_LEN   = DEF_SHORT_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  tuneStrobe_t      strb,
  input  logic [TAP_W-1:0] recTap,
  output logic             searchFin,
  output logic             skipFall,
  output logic [7:0]       finalTap,
  output logic [TAP_W:0]   winLen,
  output logic [TAP_W-1:0] winStart,
  output logic             fail,
  output logic             chosenEdge,
  output logic [TAP_W-1:0] appliedTap
);

  localparam int NUM_TAPS = 1 << TAP_W;
  localparam int LEN_W    = TAP_W + 1;
  localparam logic [LEN_W-1:0] TAPS_L      = LEN_W'(NUM_TAPS);
  localparam logic [LEN_W-1:0] EARLY_LEN_L = LEN_W'(EARLY_LEN);
  localparam logic [LEN_W-1:0] SHORT_LEN_L = LEN_W'(SHORT_LEN);
  localparam logic [TAP_W-1:0] EARLY_ST_L  = TAP_W'(EARLY_START);
  localparam logic [LEN_W-1:0] THIRD_DIV   = LEN_W'(3);

  logic [NUM_TAPS-1:0] passMap;
  logic [LEN_W-1:0]    cursor, runLen, bestLen, riseLen;
  logic [TAP_W-1:0]    runStart, bestStart, riseStart;

  // search walker
  logic             atEnd, curBit, takeRun, earlyHit;
  logic [TAP_W-1:0] candStart;

  assign atEnd     = (cursor == TAPS_L);
  assign curBit    = !atEnd && passMap[cursor[TAP_W-1:0]];
  assign takeRun   = (runLen > bestLen);
  assign candStart = takeRun ? runStart : bestStart;
  assign earlyHit  = (runLen >= EARLY_LEN_L) && (candStart < EARLY_ST_L);
  assign skipFall  = (bestLen >= EARLY_LEN_L) ||
                     ((bestStart == '0) && (bestLen >= SHORT_LEN_L));

  // edge choice and tap pick
  logic             useRise;
  logic [TAP_W-1:0] selStart, pickTap;
  logic [LEN_W-1:0] selLen, offset, pickSum;

  assign useRise  = strb.fallDone && (bestLen <= riseLen);
  assign selStart = useRise ? riseStart : bestStart;
  assign selLen   = useRise ? riseLen : bestLen;
  assign offset   = (selStart == '0) ? (selLen / THIRD_DIV) : (selLen >> 1);
  assign pickSum  = {1'b0, selStart} + offset;
  assign pickTap  = pickSum[TAP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passMap    <= '0;
      cursor     <= '0;
      runLen     <= '0;
      runStart   <= '0;
      bestLen    <= '0;
      bestStart  <= '0;
      searchFin  <= 1'b0;
      riseLen    <= '0;
      riseStart  <= '0;
      finalTap   <= '0;
      winLen     <= '0;
      winStart   <= '0;
      fail       <= 1'b0;
      chosenEdge <= 1'b0;
      appliedTap <= '0;
    end else begin
      if (strb.saveRise) begin
        riseLen   <= bestLen;
        riseStart <= bestStart;
      end
      if (strb.clearScan) begin
        passMap   <= '0;
        cursor    <= '0;
        runLen    <= '0;
        runStart  <= '0;
        bestLen   <= '0;
        bestStart <= '0;
        searchFin <= 1'b0;
      end else if (strb.recordBit) begin
        passMap[recTap] <= strb.bitVal;
      end else if (strb.searchStep && !searchFin) begin
        if (curBit) begin
          if (runLen == '0) runStart <= cursor[TAP_W-1:0];
          runLen <= runLen + 1'b1;
          cursor <= cursor + 1'b1;
        end else if (runLen != '0) begin
          if (takeRun) begin
            bestLen   <= runLen;
            bestStart <= runStart;
          end
          runLen <= '0;
          if (earlyHit || atEnd) searchFin <= 1'b1;
        end else if (atEnd) begin
          searchFin <= 1'b1;
        end else begin
          cursor <= cursor + 1'b1;
        end
      end
      if (strb.commit) begin
        fail       <= (selLen == '0);
        finalTap   <= (selLen == '0) ? 8'hFF : 8'(pickTap);
        appliedTap <= (selLen == '0) ? '0 : pickTap;
        winLen     <= selLen;
        winStart   <= selStart;
        chosenEdge <= strb.fallDone && !useRise;
      end
    end
  end

endmodule

// File: rtl/delay_window_tuner.sv
module delay_window_tuner
  import tuner_pkg::*;
#(
  parameter int TAP_W       = DEF_TAP_W,
  parameter int TRIALS      = DEF_TRIALS,
  parameter int EARLY_LEN   = DEF_EARLY_LEN,
  parameter int EARLY_START = DEF_EARLY_START,
  parameter int SHORT_LEN   = DEF_SHORT_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             testReq,
  input  logic             testAck,
  input  logic             testPass,
  output logic [TAP_W-1:0] tapSel,
  output logic             edgeSel,
  output logic [7:0]       finalTap,
  output logic [TAP_W:0]   winLen,
  output logic [TAP_W-1:0] winStart,
  output logic             done,
  output logic             fail
);

  tuneStrobe_t      strb;
  logic             searchFin, skipFall, busy, scanEdge, chosenEdge;
  logic [TAP_W-1:0] scanTap, appliedTap;

  tuner_ctrl #(.TAP_W(TAP_W), .TRIALS(TRIALS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .testAck(testAck),
    .testPass(testPass), .searchFin(searchFin), .skipFall(skipFall),
    .testReq(testReq), .scanTap(scanTap), .scanEdge(scanEdge),
    .busy(busy), .done(done), .strb(strb)
  );

  tuner_datapath #(
    .TAP_W(TAP_W), .EARLY_LEN(EARLY_LEN),
    .EARLY_START(EARLY_START), .SHORT_LEN(SHORT_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .recTap(scanTap),
    .searchFin(searchFin), .skipFall(skipFall), .finalTap(finalTap),
    .winLen(winLen), .winStart(winStart), .fail(fail),
    .chosenEdge(chosenEdge), .appliedTap(appliedTap)
  );

  assign tapSel  = busy ? scanTap : appliedTap;
  assign edgeSel = busy ? scanEdge : chosenEdge;

endmodule

// File: rtl/tuner_checker.sv
module tuner_checker #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             testReq,
  input logic             testAck,
  input logic [TAP_W-1:0] tapSel,
  input logic             edgeSel,
  input logic [7:0]       finalTap,
  input logic [TAP_W:0]   winLen,
  input logic [TAP_W-1:0] winStart,
  input logic             done,
  input logic             fail
);

  localparam int NUM_TAPS = 1 << TAP_W;

  assert_tap_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    testReq && !testAck |=> $stable(tapSel) && $stable(edgeSel));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (({1'b0, winLen} + {2'b0, winStart}) <= (TAP_W + 2)'(NUM_TAPS)));

  assert_pick_inside_R5: assert property (@(posedge clk) disable iff (!rstN)
    done && !fail |-> (winLen != '0) && (finalTap[7:TAP_W] == '0) &&
      (finalTap[TAP_W-1:0] >= winStart) &&
      ({1'b0, finalTap[TAP_W-1:0]} < ({1'b0, winStart} + winLen)));

  assert_fail_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fail == (finalTap == 8'hFF)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    testReq |-> $stable(finalTap) && $stable(winLen) && $stable(fail));

endmodule

bind delay_window_tuner tuner_checker #(.TAP_W(TAP_W)) u_tunerChecker (
  .clk(clk), .rstN(rstN), .testReq(testReq), .testAck(testAck),
  .tapSel(tapSel), .edgeSel(edgeSel), .finalTap(finalTap),
  .winLen(winLen), .winStart(winStart), .done(done), .fail(fail)
);

// File: tb/delay_window_tuner_bench.sv
module delay_window_tuner_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       testReq, testAck = 1'b0, testPass = 1'b0;
  logic [4:0] tapSel;
  logic       edgeSel;
  logic [7:0] finalTap;
  logic [5:0] winLen;
  logic [4:0] winStart;
  logic       done, fail;

  int checks = 0;
  int fails  = 0;

  logic [31:0] riseMask, fallMask;
  int riseFlaky[32];
  int fallFlaky[32];
  int cntR[32];
  int cntF[32];

  always #(CLK_PERIOD / 2) clk = ~clk;

  delay_window_tuner u_delay_window_tuner (
    .clk(clk), .rstN(rstN), .start(start), .testReq(testReq),
    .testAck(testAck), .testPass(testPass), .tapSel(tapSel),
    .edgeSel(edgeSel), .finalTap(finalTap), .winLen(winLen),
    .winStart(winStart), .done(done), .fail(fail)
  );

  // test agent: answers every request it sees at a falling edge
  initial begin
    forever begin
      @(negedge clk);
      testAck = testReq;
      if (testReq) begin
        if (edgeSel) begin
          testPass = fallMask[tapSel] && (fallFlaky[tapSel] != cntF[tapSel]);
          cntF[tapSel]++;
        end else begin
          testPass = riseMask[tapSel] && (riseFlaky[tapSel] != cntR[tapSel]);
          cntR[tapSel]++;
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] span(input int s, input int e);
    logic [31:0] m = '0;
    for (int i = s; i <= e; i++) m[i] = 1'b1;
    return m;
  endfunction

  // effective pass map: a tap passes only if all three trials pass
  function automatic logic [31:0] effMap(input logic [31:0] mask, input bit fallSide);
    logic [31:0] m;
    for (int t = 0; t < 32; t++) begin
      int k = fallSide ? fallFlaky[t] : riseFlaky[t];
      m[t] = mask[t] && !(k >= 0 && k < 3);
    end
    return m;
  endfunction

  function automatic int expTrials(input logic [31:0] mask, input bit fallSide, input int t);
    int k = fallSide ? fallFlaky[t] : riseFlaky[t];
    if (!mask[t]) return 1;
    if (k >= 0 && k < 3) return k + 1;
    return 3;
  endfunction

  // R3/R4 window search model
  task automatic bestOf(input logic [31:0] m, output int bs, output int bl);
    int s = 0;
    bs = 0;
    bl = 0;
    while (s < 32) begin
      int l = 0;
      while (s + l < 32 && m[s + l]) l++;
      if (l > bl) begin bl = l; bs = s; end
      s += (l != 0) ? l : 1;
      if (l >= 12 && bs < 4) break;
    end
  endtask

  function automatic int pickOf(input int bs, input int bl);
    if (bl == 0) return 255;
    return (bs == 0) ? (bs + bl / 3) % 32 : (bs + bl / 2) % 32;
  endfunction

  task automatic run_case(input string name, input logic [31:0] rm, input logic [31:0] fm,
                          input bit poke);
    int rs, rl, fs, fl, es, el, ep, mis, tot, expTot;
    bit skip, useFall, gotDone;
    logic [7:0] heldTap;
    riseMask = rm;
    fallMask = fm;
    for (int t = 0; t < 32; t++) begin cntR[t] = 0; cntF[t] = 0; end
    bestOf(effMap(rm, 1'b0), rs, rl);
    bestOf(effMap(fm, 1'b1), fs, fl);
    skip    = (rl >= 12) || (rs == 0 && rl >= 4);
    useFall = !skip && (fl > rl);
    es = useFall ? fs : rs;
    el = useFall ? fl : rl;
    ep = pickOf(es, el);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      fork
        begin
          repeat (60) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      join_none
    end
    gotDone = 1'b0;
    for (int c = 0; c < 3000 && !gotDone; c++) begin
      @(negedge clk);
      gotDone = done;
    end
    check("R9", {name, " done seen"}, gotDone, 1);
    if (!gotDone) return;

    check("R5", {name, " finalTap"}, finalTap, ep);
    check("R6", {name, " fail"}, fail, (el == 0));
    check("R3", {name, " winLen"}, winLen, el);
    check("R3", {name, " winStart"}, winStart, es);
    check("R8", {name, " edgeSel"}, edgeSel, useFall);
    check("R8", {name, " tapSel"}, tapSel, (el == 0) ? 0 : ep);
    mis = 0;
    tot = 0;
    expTot = 0;
    for (int t = 0; t < 32; t++) begin
      if (cntR[t] != expTrials(rm, 1'b0, t)) mis++;
      tot += cntR[t];
      expTot += expTrials(rm, 1'b0, t);
    end
    check("R2", {name, " rise trial mismatches"}, mis, 0);
    if (poke) check("R10", {name, " rise trials after busy start"}, tot, expTot);
    mis = 0;
    tot = 0;
    for (int t = 0; t < 32; t++) begin
      tot += cntF[t];
      if (!skip && cntF[t] != expTrials(fm, 1'b1, t)) mis++;
    end
    if (skip) check("R7", {name, " fall requests when skipped"}, tot, 0);
    else check("R2", {name, " fall trial mismatches"}, mis, 0);
    heldTap = finalTap;
    @(negedge clk);
    check("R9", {name, " done one cycle"}, done, 0);
    repeat (4) @(negedge clk);
    check("R9", {name, " result held"}, finalTap, heldTap);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int t = 0; t < 32; t++) begin
      riseFlaky[t] = 3;
      fallFlaky[t] = 3;
      cntR[t] = 0;
      cntF[t] = 0;
    end
    riseMask = '0;
    fallMask = '0;
    repeat (3) @(negedge clk);
    check("R9", "reset done", done, 0);
    check("R1", "reset testReq", testReq, 0);
    check("R6", "reset fail", fail, 0);
    check("R8", "reset tapSel", tapSel, 0);
    rstN = 1'b1;
    @(negedge clk);

    run_case("empty", 32'h0, 32'h0, 1'b0);              // R6 both edges empty
    run_case("full", 32'hFFFF_FFFF, 32'h0, 1'b0);       // R5 start 0 -> len/3, R7 skip
    run_case("short0", span(0, 4), 32'h0, 1'b0);        // R7 start 0 len 5 skips
    run_case("fallwin", span(20, 27), span(5, 16), 1'b0); // R8 falling longer
    run_case("tie", span(10, 15), span(3, 8), 1'b0);    // R8 tie keeps rising
    run_case("early", 32'hFFFF_7FFC, 32'h0, 1'b0);      // R4 early stop keeps first run
    riseFlaky[12] = 2;                                  // R2 third trial fails
    riseFlaky[9]  = 0;
    run_case("flaky", span(8, 19), span(0, 2), 1'b1);   // R2, R10 busy start
    riseFlaky[12] = 3;
    riseFlaky[9]  = 3;

    for (int n = 0; n < 16; n++) begin
      logic [31:0] rm, fm;
      rm = '0;
      fm = '0;
      for (int r = 0; r < 1 + int'($urandom % 3); r++) begin
        int s = int'($urandom % 32);
        rm |= span(s, (s + 1 + int'($urandom % 10) > 31) ? 31 : s + 1 + int'($urandom % 10));
        s = int'($urandom % 32);
        fm |= span(s, (s + int'($urandom % 14) > 31) ? 31 : s + int'($urandom % 14));
      end
      if ($urandom % 5 == 0) rm = $urandom;
      for (int t = 0; t < 32; t++) begin
        riseFlaky[t] = ($urandom % 8 == 0) ? int'($urandom % 3) : 3;
        fallFlaky[t] = ($urandom % 8 == 0) ? int'($urandom % 3) : 3;
      end
      run_case($sformatf("rnd%0d", n), rm, fm, (n % 4 == 1));
    end

    summary();
    $finish;
  end

endmodule